// File: doc/BRIEF.md
# Whole-Block Admission Dispatcher

This block places thread blocks from an in-order launch queue onto a single compute unit. Each queued descriptor carries a block identifier, a thread count, a register count per thread and a shared-memory byte count. The dispatcher turns that descriptor into a complete resource demand: whole warps, registers for whole warps, shared memory, and one resident-block slot. It admits the block only when every part of that demand fits in what the unit still has free. Blocks are never placed piecemeal, one warp at a time.

An admitted block leaves through a registered dispatch port. The port carries the block identifier, its warp count, the resident slot it occupies, and a lane-enable mask for each warp. The block keeps its resources until a completion notice names its slot. The freed amounts are returned to the pool, and the head of the queue can use them from the next cycle on. The queue is served strictly in order. A head block that does not fit stalls everything behind it.

Top module: `tbd_dispatch`

## Requirements
- R1: After reset the dispatch port is idle (`disp_valid` low) and the full register, shared-memory, warp and slot capacities are free.
- R2: `disp_warps` equals the thread count divided by 32, rounded up.
- R3: Bit `w*32+l` of `disp_mask` (warp `w`, lane `l`) is 1 exactly when `w*32+l` is below the thread count. All bits of warps past the last one are 0.
- R4: The register demand is `disp_warps*32*q_rpt`. A block is admitted only if this demand is no more than the free register count. A demand equal to the free count is admitted.
- R5: A block is admitted only if its shared-memory bytes are no more than the free shared-memory bytes.
- R6: A block is admitted only if its warp count is no more than the free warp slots.
- R7: At most `SLOT_CAP` (default 8) blocks are resident. A further block waits even when its other resources fit.
- R8: Only the queue head is considered. While it does not fit, `q_ready` stays low, and no later block is taken.
- R9: A completion on `done_slot` returns that block's registers, shared memory, warps and slot. The returned amounts count for admission from the cycle after the completion, not in the same cycle.
- R10: An admission in one cycle shows `disp_valid` in the next. While `disp_valid` is high and `disp_ready` is low, the port contents stay unchanged and no new block is admitted.
- R11: An admitted block takes the lowest-numbered free slot, and this slot is reported on `disp_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Queue head descriptor is present |
| q_ready | output | 1 | Queue head is admitted this cycle |
| q_id | input | 16 | Block identifier |
| q_threads | input | 9 | Threads in the block, 1 to 256 |
| q_rpt | input | 8 | Registers per thread |
| q_shm | input | 16 | Shared-memory bytes for the block |
| done_valid | input | 1 | A resident block has completed |
| done_slot | input | 3 | Slot of the completed block |
| disp_valid | output | 1 | Dispatch record is present |
| disp_ready | input | 1 | Consumer takes the dispatch record |
| disp_id | output | 16 | Identifier of the dispatched block |
| disp_warps | output | 4 | Warps in the dispatched block |
| disp_slot | output | 3 | Resident slot given to the block |
| disp_mask | output | 256 | Per-warp lane enables, warp w in bits w*32 to w*32+31 |

## Verification
The assertions assume the following about the inputs. A completion names only a slot that holds a resident block. The queue head has a thread count from 1 to 256. The head descriptor holds steady until `q_ready` accepts it. The stimulus follows these rules in three ways. It sends completions only for slots it has read back from `disp_slot`. It uses thread counts only inside that range. It keeps every descriptor fixed while it waits for admission and drops `q_valid` only after acceptance or a deliberate give-up.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    localparam int LANES        = 32;
    localparam int BLK_THR_MAX  = 256;
    localparam int BLK_WARP_MAX = BLK_THR_MAX / LANES;
    localparam int THR_W        = $clog2(BLK_THR_MAX + 1);
    localparam int WARP_W       = $clog2(BLK_WARP_MAX + 1);
    localparam int ID_W         = 16;
    localparam int RPT_W        = 8;
    localparam int SHM_W        = 16;
    localparam int CNT_W        = 24;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [THR_W-1:0] threads;
        logic [RPT_W-1:0] rpt;
        logic [SHM_W-1:0] shm;
    } blk_desc_t;

    typedef struct packed {
        logic [WARP_W-1:0] warps;
        logic [CNT_W-1:0]  regs;
        logic [SHM_W-1:0]  shm;
    } blk_cost_t;

    function automatic logic [WARP_W-1:0] warps_of(input logic [THR_W-1:0] thr);
        return WARP_W'((32'(thr) + LANES - 1) / LANES);
    endfunction
endpackage

// File: rtl/tbd_demand.sv
module tbd_demand
    import tbd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   chk_en,
    input  blk_desc_t              desc,
    output blk_cost_t              cost,
    output logic [BLK_THR_MAX-1:0] mask
);
    always_comb begin
        cost.warps = warps_of(desc.threads);
        cost.regs  = CNT_W'(cost.warps) * CNT_W'(LANES) * CNT_W'(desc.rpt);
        cost.shm   = desc.shm;
    end

    for (genvar w = 0; w < BLK_WARP_MAX; w++) begin : g_warp
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign mask[w*LANES+l] = (THR_W'(w*LANES+l) < desc.threads);
        end
    end

    // input assumption for R2: a head descriptor has a legal thread count
    assert_thread_range_R2: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (desc.threads != '0) && (32'(desc.threads) <= BLK_THR_MAX));

    // R2: warp count covers the threads with less than one spare warp
    assert_warp_cover_R2: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (32'(cost.warps) * LANES >= 32'(desc.threads)) &&
                   (32'(cost.warps) * LANES < 32'(desc.threads) + LANES));
endmodule

// File: rtl/tbd_pool.sv
module tbd_pool
    import tbd_pkg::*;
#(
    parameter int REG_CAP  = 8192,
    parameter int SHM_CAP  = 32768,
    parameter int WARP_CAP = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  blk_cost_t need,
    input  logic      take,
    input  blk_cost_t back,
    input  logic      give,
    output logic      fits
);
    logic [CNT_W-1:0] free_regs, free_shm, free_warps;

    assign fits = (need.regs <= free_regs) &&
                  (CNT_W'(need.shm) <= free_shm) &&
                  (CNT_W'(need.warps) <= free_warps);

    always_ff @(posedge clk) begin
        if (rst) begin
            free_regs  <= CNT_W'(REG_CAP);
            free_shm   <= CNT_W'(SHM_CAP);
            free_warps <= CNT_W'(WARP_CAP);
        end else begin
            free_regs  <= free_regs  - (take ? need.regs : '0)
                                     + (give ? back.regs : '0);
            free_shm   <= free_shm   - (take ? CNT_W'(need.shm) : '0)
                                     + (give ? CNT_W'(back.shm) : '0);
            free_warps <= free_warps - (take ? CNT_W'(need.warps) : '0)
                                     + (give ? CNT_W'(back.warps) : '0);
        end
    end

    // R4 R5 R6: nothing is admitted beyond what is free
    assert_no_overdraw_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> fits);

    // R9: returns never lift a pool above its capacity
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (free_regs <= CNT_W'(REG_CAP)) && (free_shm <= CNT_W'(SHM_CAP)) &&
        (free_warps <= CNT_W'(WARP_CAP)));
endmodule

// File: rtl/tbd_slots.sv
module tbd_slots
    import tbd_pkg::*;
#(
    parameter int SLOT_CAP = 8,
    localparam int SLOT_W  = (SLOT_CAP > 1) ? $clog2(SLOT_CAP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  blk_cost_t         take_cost,
    input  logic              give_req,
    input  logic [SLOT_W-1:0] give_slot,
    output logic              avail,
    output logic [SLOT_W-1:0] pick,
    output logic              give,
    output blk_cost_t         give_cost
);
    logic [SLOT_CAP-1:0] busy;
    blk_cost_t           held [SLOT_CAP];

    always_comb begin
        avail = 1'b0;
        pick  = '0;
        for (int i = SLOT_CAP - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                avail = 1'b1;
                pick  = SLOT_W'(i);
            end
        end
    end

    assign give      = give_req && busy[give_slot];
    assign give_cost = held[give_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            for (int i = 0; i < SLOT_CAP; i++) held[i] <= '0;
        end else begin
            if (give) busy[give_slot] <= 1'b0;
            if (take) begin
                busy[pick] <= 1'b1;
                held[pick] <= take_cost;
            end
        end
    end

    // R7: a block is only placed into a free slot
    assert_slot_free_R7: assert property (@(posedge clk) disable iff (rst)
        take |-> avail && !busy[pick]);

    // R9 input assumption: completions name resident blocks only
    assert_done_resident_R9: assert property (@(posedge clk) disable iff (rst)
        give_req |-> busy[give_slot]);

    // R11: a taken slot is occupied on the next cycle
    assert_slot_marked_R11: assert property (@(posedge clk) disable iff (rst)
        take |=> busy[$past(pick)]);
endmodule

// File: rtl/tbd_dispatch.sv
module tbd_dispatch
    import tbd_pkg::*;
#(
    parameter int REG_CAP  = 8192,
    parameter int SHM_CAP  = 32768,
    parameter int WARP_CAP = 32,
    parameter int SLOT_CAP = 8,
    localparam int SLOT_W  = (SLOT_CAP > 1) ? $clog2(SLOT_CAP) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   q_valid,
    output logic                   q_ready,
    input  logic [ID_W-1:0]        q_id,
    input  logic [THR_W-1:0]       q_threads,
    input  logic [RPT_W-1:0]       q_rpt,
    input  logic [SHM_W-1:0]       q_shm,
    input  logic                   done_valid,
    input  logic [SLOT_W-1:0]      done_slot,
    output logic                   disp_valid,
    input  logic                   disp_ready,
    output logic [ID_W-1:0]        disp_id,
    output logic [WARP_W-1:0]      disp_warps,
    output logic [SLOT_W-1:0]      disp_slot,
    output logic [BLK_THR_MAX-1:0] disp_mask
);
    blk_desc_t              head;
    blk_cost_t              need, back;
    logic [BLK_THR_MAX-1:0] lane_en;
    logic                   res_fit, slot_ok, give, out_free;
    logic [SLOT_W-1:0]      pick;

    assign head = '{id: q_id, threads: q_threads, rpt: q_rpt, shm: q_shm};

    tbd_demand u_demand (
        .clk(clk), .rst(rst), .chk_en(q_valid),
        .desc(head), .cost(need), .mask(lane_en)
    );

    tbd_pool #(.REG_CAP(REG_CAP), .SHM_CAP(SHM_CAP), .WARP_CAP(WARP_CAP)) u_pool (
        .clk(clk), .rst(rst), .need(need), .take(q_ready),
        .back(back), .give(give), .fits(res_fit)
    );

    tbd_slots #(.SLOT_CAP(SLOT_CAP)) u_slots (
        .clk(clk), .rst(rst), .take(q_ready), .take_cost(need),
        .give_req(done_valid), .give_slot(done_slot),
        .avail(slot_ok), .pick(pick), .give(give), .give_cost(back)
    );

    assign out_free = !disp_valid || disp_ready;
    assign q_ready  = q_valid && slot_ok && res_fit && out_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_valid <= 1'b0;
            disp_id    <= '0;
            disp_warps <= '0;
            disp_slot  <= '0;
            disp_mask  <= '0;
        end else if (q_ready) begin
            disp_valid <= 1'b1;
            disp_id    <= q_id;
            disp_warps <= need.warps;
            disp_slot  <= pick;
            disp_mask  <= lane_en;
        end else if (disp_ready) begin
            disp_valid <= 1'b0;
        end
    end

    // R8: the queue is only acknowledged while it offers a block
    assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        q_ready |-> q_valid);

    // R10: a waiting dispatch record holds still
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_id) &&
                                      $stable(disp_slot) && $stable(disp_mask));

    // R10: each admission appears on the port one cycle later
    assert_admit_shows_R10: assert property (@(posedge clk) disable iff (rst)
        q_ready |=> disp_valid && (disp_id == $past(q_id)));
endmodule

// File: tb/test_tbd_dispatch.sv
`timescale 1ns/1ps
module test_tbd_dispatch;
    import tbd_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   q_valid = 1'b0, q_ready;
    logic [ID_W-1:0]        q_id = '0;
    logic [THR_W-1:0]       q_threads = 9'd1;
    logic [RPT_W-1:0]       q_rpt = '0;
    logic [SHM_W-1:0]       q_shm = '0;
    logic                   done_valid = 1'b0;
    logic [2:0]             done_slot = '0;
    logic                   disp_valid, disp_ready = 1'b1;
    logic [ID_W-1:0]        disp_id;
    logic [WARP_W-1:0]      disp_warps;
    logic [2:0]             disp_slot;
    logic [BLK_THR_MAX-1:0] disp_mask;

    int n_checks = 0, n_fails = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    tbd_dispatch i_tbd_dispatch (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_ready(q_ready),
        .q_id(q_id), .q_threads(q_threads), .q_rpt(q_rpt), .q_shm(q_shm),
        .done_valid(done_valid), .done_slot(done_slot),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_id(disp_id),
        .disp_warps(disp_warps), .disp_slot(disp_slot), .disp_mask(disp_mask)
    );

    task automatic chk(input string req, input logic [BLK_THR_MAX-1:0] act,
                       input logic [BLK_THR_MAX-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [BLK_THR_MAX-1:0] exp_mask(input int thr);
        logic [BLK_THR_MAX-1:0] m = '0;
        for (int i = 0; i < BLK_THR_MAX; i++) m[i] = (i < thr);
        return m;
    endfunction

    // Offer one descriptor for one cycle; report acceptance, then drop it.
    task automatic offer(input int id, input int thr, input int rpt,
                         input int shm, output bit ok);
        @(negedge clk);
        q_id = ID_W'(id); q_threads = THR_W'(thr);
        q_rpt = RPT_W'(rpt); q_shm = SHM_W'(shm); q_valid = 1'b1;
        #2 ok = q_ready;
        @(negedge clk);
        q_valid = 1'b0;
        #1;
    endtask

    // Offer a block that must be admitted and check the dispatch record.
    task automatic expect_in(input string req, input int id, input int thr,
                             input int rpt, input int shm, input int slot);
        bit ok;
        offer(id, thr, rpt, shm, ok);
        chk({req, " admitted"}, BLK_THR_MAX'(ok), BLK_THR_MAX'(1));
        chk({req, " disp_valid"}, BLK_THR_MAX'(disp_valid), BLK_THR_MAX'(1));
        chk({req, " disp_id"}, BLK_THR_MAX'(disp_id), BLK_THR_MAX'(id));
        chk({req, " R11 disp_slot"}, BLK_THR_MAX'(disp_slot), BLK_THR_MAX'(slot));
        chk({req, " R2 disp_warps"}, BLK_THR_MAX'(disp_warps),
            BLK_THR_MAX'((thr + 31) / 32));
        chk({req, " R3 disp_mask"}, disp_mask, exp_mask(thr));
    endtask

    // Offer a block that must be refused, over several cycles.
    task automatic expect_out(input string req, input int id, input int thr,
                              input int rpt, input int shm);
        bit ok;
        for (int k = 0; k < 3; k++) begin
            offer(id, thr, rpt, shm, ok);
            chk({req, " refused"}, BLK_THR_MAX'(ok), BLK_THR_MAX'(0));
            chk({req, " no dispatch"}, BLK_THR_MAX'(disp_valid), BLK_THR_MAX'(0));
        end
    endtask

    task automatic release_slot(input int s);
        @(negedge clk);
        done_valid = 1'b1; done_slot = 3'(s);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 disp_valid after reset", BLK_THR_MAX'(disp_valid), BLK_THR_MAX'(0));
        chk("R1 q_ready idle", BLK_THR_MAX'(q_ready), BLK_THR_MAX'(0));
    endtask

    task automatic t_shapes;
        expect_in("R2 R3 one thread", 16'h11, 1, 1, 0, 0);
        expect_in("R2 R3 partial warp", 16'h12, 33, 1, 0, 1);
        expect_in("R2 R3 full block", 16'h13, 256, 1, 0, 2);
        expect_in("R2 R3 exact warps", 16'h14, 64, 1, 0, 3);
        for (int s = 0; s < 4; s++) release_slot(s);
    endtask

    task automatic t_regs;
        // R1 R4: exact fit of the whole register file right after clean state
        expect_in("R4 R1 exact fit", 16'h20, 64, 128, 0, 0);
        expect_out("R4 full file", 16'h21, 1, 1, 0);
        release_slot(0);
        expect_in("R4 big block", 16'h22, 32, 200, 0, 0);
        expect_out("R4 R8 head too big", 16'h23, 32, 100, 0);
        // R9: completion and waiting head in the same cycle
        @(negedge clk);
        q_id = 16'h23; q_threads = 9'd32; q_rpt = 8'd100; q_shm = '0;
        q_valid = 1'b1; done_valid = 1'b1; done_slot = 3'd0;
        #2 chk("R9 not usable same cycle", BLK_THR_MAX'(q_ready), BLK_THR_MAX'(0));
        @(negedge clk);
        done_valid = 1'b0;
        #2 chk("R9 usable next cycle", BLK_THR_MAX'(q_ready), BLK_THR_MAX'(1));
        @(negedge clk);
        q_valid = 1'b0;
        #1 chk("R9 dispatched id", BLK_THR_MAX'(disp_id), BLK_THR_MAX'(16'h23));
        chk("R9 R11 reused slot", BLK_THR_MAX'(disp_slot), BLK_THR_MAX'(0));
        release_slot(0);
    endtask

    task automatic t_shm;
        expect_in("R5 first", 16'h30, 1, 1, 20000, 0);
        expect_out("R5 one byte over", 16'h31, 1, 1, 12769);
        expect_in("R5 exact rest", 16'h32, 1, 1, 12768, 1);
        release_slot(0); release_slot(1);
    endtask

    task automatic t_warps;
        for (int b = 0; b < 4; b++)
            expect_in("R6 fill warps", 16'h40 + b, 256, 1, 0, b);
        expect_out("R6 no warp left", 16'h44, 1, 1, 0);
        release_slot(2);
        expect_in("R6 R11 after release", 16'h45, 1, 1, 0, 2);
        for (int s = 0; s < 4; s++) release_slot(s);
    endtask

    task automatic t_slots;
        for (int b = 0; b < 8; b++)
            expect_in("R7 R11 fill slots", 16'h50 + b, 1, 1, 0, b);
        expect_out("R7 slot cap", 16'h58, 1, 1, 0);
        release_slot(5);
        expect_in("R7 R11 lowest free", 16'h59, 1, 1, 0, 5);
        for (int s = 0; s < 8; s++) release_slot(s);
    endtask

    task automatic t_backpressure;
        bit ok;
        @(negedge clk);
        disp_ready = 1'b0;
        offer(16'h60, 40, 2, 0, ok);
        chk("R10 admitted", BLK_THR_MAX'(ok), BLK_THR_MAX'(1));
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1 chk("R10 held valid", BLK_THR_MAX'(disp_valid), BLK_THR_MAX'(1));
            chk("R10 held id", BLK_THR_MAX'(disp_id), BLK_THR_MAX'(16'h60));
            chk("R10 held mask", disp_mask, exp_mask(40));
        end
        @(negedge clk);
        q_id = 16'h61; q_threads = 9'd1; q_rpt = 8'd1; q_shm = '0; q_valid = 1'b1;
        #2 chk("R10 no admit while stalled", BLK_THR_MAX'(q_ready), BLK_THR_MAX'(0));
        disp_ready = 1'b1;
        #2 chk("R10 admit on drain", BLK_THR_MAX'(q_ready), BLK_THR_MAX'(1));
        @(negedge clk);
        q_valid = 1'b0;
        #1 chk("R10 next id", BLK_THR_MAX'(disp_id), BLK_THR_MAX'(16'h61));
        chk("R10 R11 next slot", BLK_THR_MAX'(disp_slot), BLK_THR_MAX'(1));
        release_slot(0); release_slot(1);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shapes();
        t_regs();
        t_shm();
        t_warps();
        t_slots();
        t_backpressure();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule